// File: doc/BRIEF.md
# Hartley Butterfly Address and Control Sequencer

This block drives a radix-2, decimation-in-time fast Hartley transform engine that processes two related butterflies at once (four points in, four points out per clock). For each such butterfly it produces the shared read address sent to all four source banks. It also produces, aligned with the arithmetic results, the three routing controls and the two destination write addresses. The controls are an input swap, a two-input compaction and an output swap. The Hartley transform's retrograde indexing shows up here as mirrored destination addresses and swap patterns that change with the stage and the position of a butterfly inside its group.

A host writes the log2 of the transform size into a 4-bit field and pulses `start`. The block then walks every stage and every butterfly, one butterfly per clock. After each stage it waits for the arithmetic pipeline to drain, and it raises `done` when the final result has been written. `pause` freezes the whole sequence, including the delayed write-side controls. Reset aborts a transform at any point. The read side and the write side are plain qualified streams with no ready signal: the engine always accepts, and `pause` is the only way to hold progress. While `pause` is high both valid strobes are low and nothing advances. The two memory banks alternate roles at each stage boundary.

Top module: `fht_agu`

## Requirements
- R1: After reset, `busy`, `done`, `rd_valid` and `wr_valid` are all low.
- R2: A `start` pulse in idle latches `cfg_log2n`, clears `done` and raises `busy` in the next cycle. Values below 2 are taken as 2 and values above 10 are taken as 10. A `start` or a `cfg_log2n` change while busy has no effect on the running transform.
- R3: With L the latched size exponent and Q = 2^(L-2), stages s = 0..L-1 run in order. In each stage, `rd_addr` counts 0..Q-1, one value per unpaused cycle with `rd_valid` high. `rd_bank` equals bit 0 of s.
- R4: `done` rises exactly (Q+5)·L+3 cycles after the clock edge that samples `start`, plus one cycle for each paused cycle. `busy` is high until then. `done` then stays high until the next accepted `start`.
- R5: In stage 0, input swap = 0, output swap = 1 and compaction = 1. Both write addresses equal the butterfly number b with its low L-2 bits reversed.
- R6: In stage 1, input swap = 1, output swap = bit 0 of b and compaction = 1.
- R7: In stages 2..L-2, input swap = bit s-2 of b and output swap = bit s-1 of b. Compaction = 1 only when the low s-1 bits of b are all zero.
- R8: In the last stage (s = L-1), input swap and output swap follow the R7 bit rule, with bit positions above L-3 reading as 0, and compaction = 1.
- R9: For s ≥ 1, let h = 2^(s-1), let g = b/h be the group, and let p be b with bit s-1 cleared. The partner address is p+h if b mod h = 0, otherwise 2^s·(p/h+1) − p. Both addresses are taken modulo Q. For even g, A = p and B = partner; for odd g, A = partner and B = p.
- R10: The controls and addresses of a butterfly appear with `wr_valid` exactly 5 unpaused cycles after its `rd_valid` cycle. `wr_bank` is the inverse of that stage's `rd_bank`.
- R11: While `pause` is high, `rd_valid` and `wr_valid` are low and neither the read sequence nor the write pipeline advances.
- R12: Asserting reset in the middle of a transform returns the block to idle with `done` low, and a following transform runs normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; aborts a transform |
| cfg_log2n | input | 4 | log2 of transform size, sampled with `start` |
| start | input | 1 | Begin a transform (accepted in idle only) |
| pause | input | 1 | Hold all progress while high |
| busy | output | 1 | A transform is in progress |
| done | output | 1 | Last transform completed; held until next start |
| rd_valid | output | 1 | Read address valid this cycle |
| rd_addr | output | 8 | Common read address for the four source banks (butterfly number) |
| rd_bank | output | 1 | Which bank pair is the source this stage |
| wr_valid | output | 1 | Write-side controls and addresses valid this cycle |
| wr_swap_in | output | 1 | Swap A and B inputs before the butterfly |
| wr_pack | output | 1 | Two-input butterfly result reordering |
| wr_swap_out | output | 1 | Swap A and B outputs before writing |
| wr_addr_a | output | 8 | Destination address for the A pair |
| wr_addr_b | output | 8 | Destination address for the B pair |
| wr_bank | output | 1 | Which bank pair is the destination |

## Verification
The checker assumes that reset is held low at time zero and that `start` and `pause` are synchronous to `clk`. It assumes nothing about `cfg_log2n`, because the value is clamped and latched. The stimulus drives `start` only as single-cycle pulses and applies `pause` only while a transform is in flight. Inputs change only at falling edges. The write-side model in the bench recomputes every tuple from the requirement equations for sizes 4, 16, 64 and 1024. It also tracks how many unpaused cycles separate each read issue from its matching write.

// File: rtl/fht_agu_pkg.sv
package fht_agu_pkg;

  // Sequencer phases: idle, start-up warm-up, butterfly issue, pipeline drain
  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_WARM,
    SEQ_ISSUE,
    SEQ_DRAIN
  } seq_state_e;

  // Smallest supported size exponent (four points, one butterfly)
  localparam int unsigned MIN_LOG2N = 2;

  // Width of the host size field
  localparam int unsigned CFG_W = 4;

endpackage

// File: rtl/fht_agu_seq.sv
module fht_agu_seq
  import fht_agu_pkg::*;
#(
  parameter int unsigned MAX_LOG2N = 10,
  parameter int unsigned WARM_CYC  = 3,
  parameter int unsigned DRAIN_CYC = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   pause,
  input  logic [CFG_W-1:0]       cfg_log2n,
  output logic                   busy,
  output logic                   done,
  output logic                   issue,
  output logic [CFG_W-1:0]       log2n_q,
  output logic [CFG_W-1:0]       stage,
  output logic [MAX_LOG2N-3:0]   bfly
);

  localparam int unsigned BW    = MAX_LOG2N - 2;
  localparam int unsigned TMAX  = (WARM_CYC > DRAIN_CYC) ? WARM_CYC : DRAIN_CYC;
  localparam int unsigned TW    = $clog2(TMAX + 1);

  seq_state_e        state;
  logic [TW-1:0]     tmr;
  logic [CFG_W-1:0]  cfg_eff;
  logic [BW-1:0]     last_b;
  logic              last_stage;

  // Clamp the requested size into the supported range
  always_comb begin
    if (cfg_log2n < CFG_W'(MIN_LOG2N))      cfg_eff = CFG_W'(MIN_LOG2N);
    else if (cfg_log2n > CFG_W'(MAX_LOG2N)) cfg_eff = CFG_W'(MAX_LOG2N);
    else                                    cfg_eff = cfg_log2n;
  end

  // Highest butterfly number: low (L-2) bits set
  assign last_b     = ~({BW{1'b1}} << (log2n_q - CFG_W'(MIN_LOG2N)));
  assign last_stage = (stage == log2n_q - CFG_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SEQ_IDLE;
      tmr     <= '0;
      stage   <= '0;
      bfly    <= '0;
      log2n_q <= CFG_W'(MIN_LOG2N);
      done    <= 1'b0;
    end else if (state == SEQ_IDLE && start) begin
      state   <= SEQ_WARM;
      tmr     <= '0;
      stage   <= '0;
      bfly    <= '0;
      log2n_q <= cfg_eff;
      done    <= 1'b0;
    end else if (!pause) begin
      unique case (state)
        SEQ_WARM: begin
          if (tmr == TW'(WARM_CYC - 1)) begin
            state <= SEQ_ISSUE;
            tmr   <= '0;
          end else begin
            tmr <= tmr + TW'(1);
          end
        end
        SEQ_ISSUE: begin
          if (bfly == last_b) begin
            state <= SEQ_DRAIN;
            bfly  <= '0;
            tmr   <= '0;
          end else begin
            bfly <= bfly + BW'(1);
          end
        end
        SEQ_DRAIN: begin
          if (tmr == TW'(DRAIN_CYC - 1)) begin
            tmr <= '0;
            if (last_stage) begin
              state <= SEQ_IDLE;
              done  <= 1'b1;
            end else begin
              state <= SEQ_ISSUE;
              stage <= stage + CFG_W'(1);
            end
          end else begin
            tmr <= tmr + TW'(1);
          end
        end
        default: ;
      endcase
    end
  end

  assign busy  = (state != SEQ_IDLE);
  assign issue = (state == SEQ_ISSUE);

endmodule

// File: rtl/fht_agu_map.sv
module fht_agu_map
  import fht_agu_pkg::*;
#(
  parameter int unsigned MAX_LOG2N = 10
) (
  input  logic [CFG_W-1:0]      log2n,
  input  logic [CFG_W-1:0]      stage,
  input  logic [MAX_LOG2N-3:0]  bfly,
  output logic                  sw_in,
  output logic                  pack,
  output logic                  sw_out,
  output logic [MAX_LOG2N-3:0]  addr_a,
  output logic [MAX_LOG2N-3:0]  addr_b
);

  localparam int unsigned BW = MAX_LOG2N - 2;

  logic [CFG_W-1:0] sm1, sm2;
  logic [BW-1:0]    rev, rev_sh, qmask;
  logic [BW-1:0]    half, lowm, base, grp, mirror, partner;
  logic             first, odd, last, bit_i, bit_o;

  // Plain bit reversal across the full width, then aligned to L-2 bits
  for (genvar k = 0; k < BW; k++) begin : g_rev
    assign rev[k] = bfly[BW-1-k];
  end
  assign rev_sh = rev >> (CFG_W'(MAX_LOG2N) - log2n);

  assign sm1   = stage - CFG_W'(1);
  assign sm2   = stage - CFG_W'(2);
  assign qmask = ~({BW{1'b1}} << (log2n - CFG_W'(MIN_LOG2N)));
  assign last  = (stage == log2n - CFG_W'(1));

  // Group geometry; all arithmetic is modulo 2^BW, a multiple of Q
  assign half    = BW'(1) << sm1;
  assign lowm    = half - BW'(1);
  assign first   = ((bfly & lowm) == '0);
  assign odd     = |(bfly & half);
  assign base    = bfly & ~half;
  assign grp     = base >> sm1;
  assign mirror  = ((grp + BW'(1)) << stage) - base;
  assign partner = first ? (base + half) : mirror;

  assign bit_i = |((bfly >> sm2) & BW'(1));
  assign bit_o = |((bfly >> sm1) & BW'(1));

  always_comb begin
    if (stage == '0) begin
      sw_in  = 1'b0;
      sw_out = 1'b1;
      pack   = 1'b1;
      addr_a = rev_sh;
      addr_b = rev_sh;
    end else begin
      sw_in  = (stage == CFG_W'(1)) ? 1'b1 : bit_i;
      sw_out = bit_o;
      pack   = (stage == CFG_W'(1) || last) ? 1'b1 : first;
      if (odd) begin
        addr_a = partner & qmask;
        addr_b = base & qmask;
      end else begin
        addr_a = base & qmask;
        addr_b = partner & qmask;
      end
    end
  end

endmodule

// File: rtl/fht_agu_pipe.sv
module fht_agu_pipe #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_stg
    if (k == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  stg[k] <= '0;
        else if (en) stg[k] <= d;
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  stg[k] <= '0;
        else if (en) stg[k] <= stg[k-1];
      end
    end
  end

  assign q = stg[DEPTH-1];

endmodule

// File: rtl/fht_agu.sv
module fht_agu
  import fht_agu_pkg::*;
#(
  parameter int unsigned MAX_LOG2N = 10,
  parameter int unsigned WARM_CYC  = 3,
  parameter int unsigned PIPE_LAT  = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [3:0]           cfg_log2n,
  input  logic                 start,
  input  logic                 pause,
  output logic                 busy,
  output logic                 done,
  output logic                 rd_valid,
  output logic [MAX_LOG2N-3:0] rd_addr,
  output logic                 rd_bank,
  output logic                 wr_valid,
  output logic                 wr_swap_in,
  output logic                 wr_pack,
  output logic                 wr_swap_out,
  output logic [MAX_LOG2N-3:0] wr_addr_a,
  output logic [MAX_LOG2N-3:0] wr_addr_b,
  output logic                 wr_bank
);

  localparam int unsigned BW = MAX_LOG2N - 2;
  localparam int unsigned PW = 5 + 2 * BW;

  logic             issue;
  logic [CFG_W-1:0] log2n_q, stage;
  logic [BW-1:0]    bfly, a_now, b_now;
  logic             swi_now, pk_now, swo_now;
  logic [PW-1:0]    bundle_in, bundle_out;

  fht_agu_seq #(
    .MAX_LOG2N (MAX_LOG2N),
    .WARM_CYC  (WARM_CYC),
    .DRAIN_CYC (PIPE_LAT)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .pause     (pause),
    .cfg_log2n (cfg_log2n),
    .busy      (busy),
    .done      (done),
    .issue     (issue),
    .log2n_q   (log2n_q),
    .stage     (stage),
    .bfly      (bfly)
  );

  fht_agu_map #(
    .MAX_LOG2N (MAX_LOG2N)
  ) u_map (
    .log2n  (log2n_q),
    .stage  (stage),
    .bfly   (bfly),
    .sw_in  (swi_now),
    .pack   (pk_now),
    .sw_out (swo_now),
    .addr_a (a_now),
    .addr_b (b_now)
  );

  assign rd_valid = issue & ~pause;
  assign rd_addr  = bfly;
  assign rd_bank  = stage[0];

  assign bundle_in = {rd_valid, swi_now, pk_now, swo_now, ~stage[0], a_now, b_now};

  fht_agu_pipe #(
    .W     (PW),
    .DEPTH (PIPE_LAT)
  ) u_pipe (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (~pause),
    .d     (bundle_in),
    .q     (bundle_out)
  );

  assign wr_valid    = bundle_out[PW-1] & ~pause;
  assign wr_swap_in  = bundle_out[PW-2];
  assign wr_pack     = bundle_out[PW-3];
  assign wr_swap_out = bundle_out[PW-4];
  assign wr_bank     = bundle_out[PW-5];
  assign wr_addr_a   = bundle_out[2*BW-1:BW];
  assign wr_addr_b   = bundle_out[BW-1:0];

endmodule

// File: rtl/fht_agu_chk.sv
module fht_agu_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         pause,
  input logic         busy,
  input logic         done,
  input logic         rd_valid,
  input logic [W-1:0] rd_addr,
  input logic         wr_valid,
  input logic         wr_pack,
  input logic [W-1:0] wr_addr_a,
  input logic [W-1:0] wr_addr_b
);

  a_r11_pause_blocks_valid: assert property (@(posedge clk) disable iff (!rst_n)
    pause |-> (!rd_valid && !wr_valid));

  a_r11_pause_holds_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (pause && busy) |=> $stable(rd_addr));

  a_r3_addr_steps_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(rd_valid) && rd_addr != '0) |-> (rd_addr == $past(rd_addr) + W'(1)));

  a_r3_issue_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> busy);

  a_r4_done_excludes_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  a_r4_done_follows_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));

  a_r9_mirror_distinct: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_pack) |-> (wr_addr_a != wr_addr_b));

endmodule

bind fht_agu fht_agu_chk #(.W(MAX_LOG2N - 2)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pause     (pause),
  .busy      (busy),
  .done      (done),
  .rd_valid  (rd_valid),
  .rd_addr   (rd_addr),
  .wr_valid  (wr_valid),
  .wr_pack   (wr_pack),
  .wr_addr_a (wr_addr_a),
  .wr_addr_b (wr_addr_b)
);

// File: tb/fht_agu_bench.sv
module fht_agu_bench;

  localparam int CLK_PERIOD = 10;
  localparam int MAXL       = 10;
  localparam int BW         = MAXL - 2;
  localparam int PIPE       = 5;
  localparam int WARM       = 3;

  logic          clk, rst_n, start, pause;
  logic [3:0]    cfg_log2n;
  logic          busy, done, rd_valid, rd_bank, wr_valid;
  logic          wr_swap_in, wr_pack, wr_swap_out, wr_bank;
  logic [BW-1:0] rd_addr, wr_addr_a, wr_addr_b;

  fht_agu #(.MAX_LOG2N(MAXL), .WARM_CYC(WARM), .PIPE_LAT(PIPE)) u_fht_agu (
    .clk(clk), .rst_n(rst_n), .cfg_log2n(cfg_log2n), .start(start), .pause(pause),
    .busy(busy), .done(done), .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_bank(rd_bank),
    .wr_valid(wr_valid), .wr_swap_in(wr_swap_in), .wr_pack(wr_pack),
    .wr_swap_out(wr_swap_out), .wr_addr_a(wr_addr_a), .wr_addr_b(wr_addr_b),
    .wr_bank(wr_bank)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int npass = 0;
  int nfail = 0;

  function automatic void chk(input bit ok, input string tag, input int act, input int expv);
    if (ok) npass++;
    else begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endfunction

  // Reference model written from the requirement equations
  function automatic void exp_tuple(input int L, input int s, input int b,
                                    output int ei, output int ec, output int eo,
                                    output int ea, output int eb);
    int q, h, g, p, prt, r;
    q = 1 << (L - 2);
    if (s == 0) begin
      r = 0;
      for (int k = 0; k < L - 2; k++) if (((b >> k) & 1) == 1) r = r | (1 << (L - 3 - k));
      ei = 0; eo = 1; ec = 1; ea = r; eb = r;
      return;
    end
    h  = 1 << (s - 1);
    ei = (s == 1) ? 1 : ((b >> (s - 2)) & 1);
    eo = (b >> (s - 1)) & 1;
    ec = (s == 1 || s == L - 1) ? 1 : (((b % h) == 0) ? 1 : 0);
    g  = b / h;
    p  = (g % 2 == 1) ? b - h : b;
    prt = ((b % h) == 0) ? p + h : (2 * h) * (p / h + 1) - p;
    prt = prt % q;
    p   = p % q;
    if (g % 2 == 1) begin ea = prt; eb = p; end
    else            begin ea = p;   eb = prt; end
  endfunction

  // Monitor state
  bit mon_en = 1'b0;
  int cur_L = 2;
  int rd_idx, wr_idx, ucyc;
  int t_issue [4096];

  always @(negedge clk) begin
    #1;
    if (mon_en) begin
      int q, s, b, ei, ec, eo, ea, eb;
      string tc, ta;
      q = 1 << (cur_L - 2);
      if (pause) chk(!rd_valid && !wr_valid, "R11 valid during pause", {rd_valid, wr_valid}, 0);
      if (rd_valid && rd_idx < 4096) begin
        s = rd_idx / q; b = rd_idx % q;
        chk(int'(rd_addr) == b, "R3 rd_addr", int'(rd_addr), b);
        chk(int'(rd_bank) == s % 2, "R3 rd_bank", int'(rd_bank), s % 2);
        t_issue[rd_idx] = ucyc;
        rd_idx++;
      end
      if (wr_valid && wr_idx < 4096) begin
        s = wr_idx / q; b = wr_idx % q;
        exp_tuple(cur_L, s, b, ei, ec, eo, ea, eb);
        tc = (s == 0) ? "R5" : (s == 1) ? "R6" : (s == cur_L - 1) ? "R8" : "R7";
        ta = (s == 0) ? "R5 addr" : "R9 addr";
        chk(int'(wr_swap_in)  == ei, {tc, " swap_in"},  int'(wr_swap_in),  ei);
        chk(int'(wr_pack)     == ec, {tc, " pack"},     int'(wr_pack),     ec);
        chk(int'(wr_swap_out) == eo, {tc, " swap_out"}, int'(wr_swap_out), eo);
        chk(int'(wr_addr_a)   == ea, {ta, " A"},        int'(wr_addr_a),   ea);
        chk(int'(wr_addr_b)   == eb, {ta, " B"},        int'(wr_addr_b),   eb);
        chk(int'(wr_bank) == 1 - (s % 2), "R10 wr_bank", int'(wr_bank), 1 - (s % 2));
        chk(ucyc - t_issue[wr_idx] == PIPE, "R10 latency", ucyc - t_issue[wr_idx], PIPE);
        // Hand-derived spot values for the 64-point case
        if (cur_L == 6 && s == 0 && b == 1) chk(int'(wr_addr_a) == 8, "R5 bitrev spot", int'(wr_addr_a), 8);
        if (cur_L == 6 && s == 3 && b == 5) chk(int'(wr_addr_a) == 7, "R9 odd-group spot", int'(wr_addr_a), 7);
        if (cur_L == 6 && s == 5 && b == 9) chk(int'(wr_addr_b) == 7, "R9 wrap spot", int'(wr_addr_b), 7);
        wr_idx++;
      end
      if (!pause) ucyc++;
    end
  end

  task automatic do_run(input logic [3:0] cfg, input int expL, input int p_at,
                        input int p_len, input int poke_at, output int cyc);
    cur_L = expL; rd_idx = 0; wr_idx = 0; ucyc = 0;
    @(negedge clk);
    cfg_log2n = cfg; start = 1'b1; mon_en = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && !done, "R2 start accepted", {busy, done}, 2);
    cyc = 0;
    while (!done && cyc < 20000) begin
      if (cyc == p_at) pause = 1'b1;
      if (cyc == p_at + p_len) pause = 1'b0;
      if (cyc == poke_at) begin start = 1'b1; cfg_log2n = 4'd7; end
      else start = 1'b0;
      @(negedge clk);
      cyc++;
    end
    pause = 1'b0; start = 1'b0;
    #2;
    mon_en = 1'b0;
  endtask

  function automatic int total_cyc(input int L);
    return ((1 << (L - 2)) + PIPE) * L + WARM;
  endfunction

  task automatic t_reset_state;
    chk(!busy && !done, "R1 busy/done after reset", {busy, done}, 0);
    chk(!rd_valid && !wr_valid, "R1 valids after reset", {rd_valid, wr_valid}, 0);
  endtask

  task automatic t_size(input int L);
    int cyc, q;
    q = 1 << (L - 2);
    do_run(4'(L), L, -1, 0, -1, cyc);
    chk(cyc == total_cyc(L), "R4 cycle count", cyc, total_cyc(L));
    chk(rd_idx == L * q, "R3 issue count", rd_idx, L * q);
    chk(wr_idx == L * q, "R10 write count", wr_idx, L * q);
    chk(!busy, "R4 idle at end", busy, 0);
    repeat (3) @(negedge clk);
    chk(done, "R4 done held", done, 1);
  endtask

  task automatic t_clamp;
    int cyc;
    do_run(4'd1, 2, -1, 0, -1, cyc);
    chk(cyc == total_cyc(2), "R2 clamp low cycles", cyc, total_cyc(2));
    chk(wr_idx == 2, "R2 clamp low writes", wr_idx, 2);
    do_run(4'd13, 10, -1, 0, -1, cyc);
    chk(cyc == total_cyc(10), "R2 clamp high cycles", cyc, total_cyc(10));
  endtask

  task automatic t_pause;
    int cyc;
    do_run(4'd6, 6, 20, 7, -1, cyc);
    chk(cyc == total_cyc(6) + 7, "R11 paused cycle count", cyc, total_cyc(6) + 7);
    chk(wr_idx == 96, "R11 writes after pause", wr_idx, 96);
    do_run(4'd4, 4, 8, 3, -1, cyc);
    chk(cyc == total_cyc(4) + 3, "R11 pause in drain", cyc, total_cyc(4) + 3);
  endtask

  task automatic t_restart_ignored;
    int cyc;
    do_run(4'd4, 4, -1, 0, 10, cyc);
    chk(cyc == total_cyc(4), "R2 start while busy ignored", cyc, total_cyc(4));
    chk(wr_idx == 16, "R2 size unchanged", wr_idx, 16);
  endtask

  task automatic t_abort;
    int cyc;
    @(negedge clk);
    cfg_log2n = 4'd6; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (50) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!busy && !done, "R12 abort busy/done", {busy, done}, 0);
    chk(!rd_valid && !wr_valid, "R12 abort valids", {rd_valid, wr_valid}, 0);
    rst_n = 1'b1;
    do_run(4'd4, 4, -1, 0, -1, cyc);
    chk(cyc == total_cyc(4), "R12 recovery cycles", cyc, total_cyc(4));
    chk(wr_idx == 16, "R12 recovery writes", wr_idx, 16);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", npass, npass + nfail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; pause = 1'b0; cfg_log2n = 4'd0;
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    t_size(2);
    t_size(4);
    t_size(6);
    t_size(10);
    t_clamp();
    t_pause();
    t_restart_ignored();
    t_abort();
    $display("%0d/%0d checks passed", npass, npass + nfail);
    $finish;
  end

endmodule